// File: doc/BRIEF.md
# Three-slot bundle dispersal stage

This block sits between instruction fetch and the execution ports of a wide in-order core. Each 128-bit bundle carries three 41-bit operations and a 5-bit template. The template fixes the unit class of every slot and marks the issue-group boundaries. The block holds a window of two bundles. Every cycle it walks the pending slots oldest first and hands each one to a free execution port of the right class. The walk halts at the first slot that finds no port, and also at a group boundary once something has gone out that cycle. Slots that do not go out wait in the window and are tried again on the next cycle.

Bundles arrive on a two-lane valid/ready stream. `in_ready[0]` says at least one window entry will be free at the next edge, given this cycle's issue. `in_ready[1]` says both entries will be free. Lane 0 transfers when `in_valid[0] & in_ready[0]`. Lane 1 transfers only when lane 0 transfers in the same cycle and also `in_valid[1] & in_ready[1]`. A source whose lane 1 bundle was not taken must present that bundle on lane 0 afterwards. Ready never depends on valid.

The issue side has no back-pressure. A port whose valid bit is high consumes its operation in that cycle. The issue outputs are combinational from the window registers, so a bundle accepted at an edge can issue in the cycle that follows.

Top module: `vdisp_top`

## Requirements
- R1: In a bundle, bits [4:0] are the template and slot k occupies bits [5+41k +: 41]. An issued operation appears unchanged on its port's 41-bit field in `issue_op`, where port p uses bits [41p +: 41].
- R2: Template bits [4:1] select the slot classes (slot 0, 1, 2): 0 MII, 1 MI_I, 2 MLX, 4 MMI, 5 M_MI, 6 MFI, 7 MMF, 8 MIB, 9 MBB, 11 BBB, 12 MMB, 14 MFB. Each operation goes only to a port of its class. `issue_valid` bit order is M0, M1, I0, I1, F0, F1, B0, B1, B2 from bit 0.
- R3: A group boundary follows slot 1 for value 1 of bits [4:1] and follows slot 0 for value 5. Template bit 0 set places a boundary after slot 2. An operation beyond a boundary never issues in the same cycle as an operation before it.
- R4: At most 2 M, 2 I, 2 F and 3 B ports are used per cycle. Operations left without a port stay in the window and issue in a later cycle.
- R5: Slots issue in program order across both window entries. The first slot that finds no port blocks every later slot that cycle. Within a class, ports fill from the lowest index.
- R6: An MLX bundle's slots 1 and 2 form one long operation. It takes a free I port, or else a free B port. Its port carries slot 1 on `issue_op`, slot 2 on `issue_ext`, and the port's `issue_long` bit is set. `issue_long` is never set on an M or F port or on an idle port.
- R7: A bundle whose bits [4:1] are 3, 10, 13 or 15 is accepted, issues nothing, and raises `tmpl_err` for exactly the one cycle after its acceptance.
- R8: `in_ready` is 2'b11 when both entries free up this cycle, 2'b01 when exactly one does, and 2'b00 when the older entry still has work after this cycle. Lane 1 is never taken without lane 0.
- R9: Once the older bundle is fully issued, the younger one becomes the older and one new bundle is taken. When both are fully issued, two new bundles may be taken at once. A full window always issues at least one operation.
- R10: During and right after reset the window is empty, no port is valid, `in_ready` is 2'b11 and `tmpl_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Per-lane bundle valid; lane 1 only together with lane 0 |
| in_ready | output | 2 | Lane 0: one entry free; lane 1: both entries free |
| in_bundle | input | 256 | Lane 0 bundle in [127:0], lane 1 bundle in [255:128] |
| issue_valid | output | 9 | Per-port issue strobe, order M0 M1 I0 I1 F0 F1 B0 B1 B2 |
| issue_op | output | 369 | Per-port 41-bit operation, port p at [41p +: 41] |
| issue_ext | output | 369 | Per-port second half of a long operation |
| issue_long | output | 9 | Port carries a two-slot long operation |
| tmpl_err | output | 1 | One-cycle pulse after a reserved-template bundle was accepted |

## Verification
Pairs of templates are loaded into an empty window, and the issued port pattern is compared cycle by cycle. Same-class pairs such as MII+MII and BBB+MBB use up one port class and show the in-order block and the spill into the next cycle. Pairs with an internal or end boundary (MI_I, M_MI, odd templates) separate a correct stop rule from one that lets the younger group issue early. MLX placed behind a bundle that has already taken both I ports tells apart the I-first and B-fallback placement of the long operation. Directed sequences that offer new bundles while the window is part full separate single from double rotation, and they show that lane 1 is refused while only one entry is free.

// File: rtl/vdisp_pkg.sv
package vdisp_pkg;
  localparam int BUNDLE_W = 128;
  localparam int SLOT_W   = 41;
  localparam int TMPL_W   = 5;
  localparam int NSLOT    = 3;
  localparam int NLANE    = 2;

  typedef enum logic [2:0] {
    UT_NONE = 3'd0,
    UT_M    = 3'd1,
    UT_I    = 3'd2,
    UT_F    = 3'd3,
    UT_B    = 3'd4,
    UT_LX   = 3'd5
  } unit_e;

  typedef struct packed {
    logic                          live;
    logic [NSLOT-1:0][SLOT_W-1:0]  op;
    unit_e [NSLOT-1:0]             kind;
    logic [NSLOT-1:0]              stop_after;
    logic [NSLOT-1:0]              pend;
    logic                          bad;
  } entry_t;
endpackage

// File: rtl/vdisp_tmpl_dec.sv
module vdisp_tmpl_dec
  import vdisp_pkg::*;
(
  input  logic [BUNDLE_W-1:0] bundle,
  output entry_t              ent
);
  logic [3:0] tsel;
  unit_e      k0, k1, k2;
  logic       s0, s1, bad;

  assign tsel = bundle[4:1];

  always_comb begin
    k0 = UT_M; k1 = UT_NONE; k2 = UT_NONE;
    s0 = 1'b0; s1 = 1'b0; bad = 1'b0;
    case (tsel)
      4'd0:  begin k1 = UT_I;  k2 = UT_I; end
      4'd1:  begin k1 = UT_I;  k2 = UT_I; s1 = 1'b1; end
      4'd2:  begin k1 = UT_LX; k2 = UT_NONE; end
      4'd4:  begin k1 = UT_M;  k2 = UT_I; end
      4'd5:  begin k1 = UT_M;  k2 = UT_I; s0 = 1'b1; end
      4'd6:  begin k1 = UT_F;  k2 = UT_I; end
      4'd7:  begin k1 = UT_M;  k2 = UT_F; end
      4'd8:  begin k1 = UT_I;  k2 = UT_B; end
      4'd9:  begin k1 = UT_B;  k2 = UT_B; end
      4'd11: begin k0 = UT_B;  k1 = UT_B; k2 = UT_B; end
      4'd12: begin k1 = UT_M;  k2 = UT_B; end
      4'd14: begin k1 = UT_F;  k2 = UT_B; end
      default: begin k0 = UT_NONE; bad = 1'b1; end
    endcase
  end

  always_comb begin
    ent      = '0;
    ent.live = 1'b1;
    ent.bad  = bad;
    for (int s = 0; s < NSLOT; s++) begin
      ent.op[s] = bundle[TMPL_W + SLOT_W*s +: SLOT_W];
    end
    ent.kind[0] = k0;
    ent.kind[1] = k1;
    ent.kind[2] = k2;
    if (!bad) begin
      ent.stop_after = {bundle[0], s1, s0};
      ent.pend       = (k1 == UT_LX) ? 3'b011 : 3'b111;
    end
  end
endmodule

// File: rtl/vdisp_alloc.sv
module vdisp_alloc
  import vdisp_pkg::*;
#(
  parameter int NM = 2,
  parameter int NI = 2,
  parameter int NF = 2,
  parameter int NB = 3,
  localparam int NPORT = NM + NI + NF + NB
)(
  input  entry_t [NLANE-1:0]             win,
  output logic   [NPORT-1:0]             pv,
  output logic   [NPORT-1:0][SLOT_W-1:0] pop,
  output logic   [NPORT-1:0][SLOT_W-1:0] pext,
  output logic   [NPORT-1:0]             plong,
  output logic   [NLANE-1:0][NSLOT-1:0]  issued
);
  localparam int BM = 0;
  localparam int BI = NM;
  localparam int BF = NM + NI;
  localparam int BB = NM + NI + NF;

  always_comb begin
    int   mu, iu, fu, bu, idx;
    logic halt, any, lng;
    pv = '0; pop = '0; pext = '0; plong = '0; issued = '0;
    mu = 0; iu = 0; fu = 0; bu = 0;
    halt = 1'b0; any = 1'b0;
    for (int e = 0; e < NLANE; e++) begin
      for (int s = 0; s < NSLOT; s++) begin
        idx = -1;
        lng = 1'b0;
        if (win[e].live && win[e].pend[s] && !halt) begin
          case (win[e].kind[s])
            UT_M: if (mu < NM) begin idx = BM + mu; mu++; end
            UT_I: if (iu < NI) begin idx = BI + iu; iu++; end
            UT_F: if (fu < NF) begin idx = BF + fu; fu++; end
            UT_B: if (bu < NB) begin idx = BB + bu; bu++; end
            UT_LX: begin
              lng = 1'b1;
              if (iu < NI) begin idx = BI + iu; iu++; end
              else if (bu < NB) begin idx = BB + bu; bu++; end
            end
            default: idx = -1;
          endcase
          if (idx >= 0) begin
            for (int q = 0; q < NPORT; q++) begin
              if (q == idx) begin
                pv[q]    = 1'b1;
                pop[q]   = win[e].op[s];
                pext[q]  = lng ? win[e].op[NSLOT-1] : '0;
                plong[q] = lng;
              end
            end
            issued[e][s] = 1'b1;
            any = 1'b1;
          end else begin
            halt = 1'b1;
          end
        end
        if (win[e].live && win[e].stop_after[s] && any) halt = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vdisp_window.sv
module vdisp_window
  import vdisp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic   [NLANE-1:0]            in_valid,
  input  entry_t [NLANE-1:0]            lane,
  input  logic   [NLANE-1:0][NSLOT-1:0] issued,
  output entry_t [NLANE-1:0]            win,
  output logic   [NLANE-1:0]            in_ready,
  output logic   [NLANE-1:0]            take
);
  entry_t [NLANE-1:0] nxt;
  entry_t             old_u, yng_u;
  logic               old_done, yng_done;
  logic [1:0]         surv;

  always_comb begin
    old_u      = win[0];
    old_u.pend = win[0].pend & ~issued[0];
    yng_u      = win[1];
    yng_u.pend = win[1].pend & ~issued[1];
    old_done   = !win[0].live || (old_u.pend == '0);
    yng_done   = !win[1].live || (yng_u.pend == '0);
    if (!old_done)      surv = win[1].live ? 2'd2 : 2'd1;
    else if (!yng_done) surv = 2'd1;
    else                surv = 2'd0;
    in_ready[0] = (surv != 2'd2);
    in_ready[1] = (surv == 2'd0);
    take[0]     = in_valid[0] & in_ready[0];
    take[1]     = take[0] & in_valid[1] & in_ready[1];
  end

  always_comb begin
    nxt = '0;
    if (!old_done) begin
      nxt[0] = old_u;
      if (win[1].live) nxt[1] = yng_u;
      else if (take[0]) nxt[1] = lane[0];
    end else if (!yng_done) begin
      nxt[0] = yng_u;
      if (take[0]) nxt[1] = lane[0];
    end else begin
      if (take[0]) nxt[0] = lane[0];
      if (take[1]) nxt[1] = lane[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) win <= '0;
    else        win <= nxt;
  end
endmodule

// File: rtl/vdisp_top.sv
module vdisp_top
  import vdisp_pkg::*;
#(
  parameter int NM = 2,
  parameter int NI = 2,
  parameter int NF = 2,
  parameter int NB = 3
)(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NLANE-1:0]                     in_valid,
  output logic [NLANE-1:0]                     in_ready,
  input  logic [NLANE*BUNDLE_W-1:0]            in_bundle,
  output logic [NM+NI+NF+NB-1:0]               issue_valid,
  output logic [(NM+NI+NF+NB)*SLOT_W-1:0]      issue_op,
  output logic [(NM+NI+NF+NB)*SLOT_W-1:0]      issue_ext,
  output logic [NM+NI+NF+NB-1:0]               issue_long,
  output logic                                 tmpl_err
);
  localparam int NPORT = NM + NI + NF + NB;

  entry_t [NLANE-1:0]             lane;
  entry_t [NLANE-1:0]             win;
  logic   [NLANE-1:0][NSLOT-1:0]  issued;
  logic   [NLANE-1:0]             take;
  logic   [NPORT-1:0][SLOT_W-1:0] pop, pext;

  for (genvar g = 0; g < NLANE; g++) begin : g_dec
    vdisp_tmpl_dec u_dec (
      .bundle (in_bundle[g*BUNDLE_W +: BUNDLE_W]),
      .ent    (lane[g])
    );
  end

  vdisp_window u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .lane     (lane),
    .issued   (issued),
    .win      (win),
    .in_ready (in_ready),
    .take     (take)
  );

  vdisp_alloc #(.NM(NM), .NI(NI), .NF(NF), .NB(NB)) u_alloc (
    .win    (win),
    .pv     (issue_valid),
    .pop    (pop),
    .pext   (pext),
    .plong  (issue_long),
    .issued (issued)
  );

  assign issue_op  = pop;
  assign issue_ext = pext;

  always_ff @(posedge clk) begin
    if (!rst_n) tmpl_err <= 1'b0;
    else        tmpl_err <= (take[0] & lane[0].bad) | (take[1] & lane[1].bad);
  end
endmodule

// File: rtl/vdisp_chk.sv
module vdisp_chk #(
  parameter int NM = 2,
  parameter int NI = 2,
  parameter int NF = 2,
  parameter int NB = 3,
  localparam int NPORT = NM + NI + NF + NB
)(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       in_valid,
  input logic [1:0]       in_ready,
  input logic [NPORT-1:0] issue_valid,
  input logic [NPORT-1:0] issue_long,
  input logic             tmpl_err
);
  localparam int BI = NM;
  localparam int BF = NM + NI;
  localparam int BB = NM + NI + NF;

  // R10
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (issue_valid == '0 && in_ready == 2'b11 && !tmpl_err));

  // R8
  ready_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready[1] |-> in_ready[0]);

  // R9
  full_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready[0] |-> (issue_valid != '0));

  // R7
  err_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmpl_err |-> $past(in_valid[0] && in_ready[0]));

  // R6
  long_on_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_long & ~issue_valid) == '0);

  for (genvar p = 0; p < BI; p++) begin : g_mlong
    // R6
    long_not_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_long[p]);
  end

  for (genvar p = BF; p < BB; p++) begin : g_flong
    // R6
    long_not_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_long[p]);
  end

  for (genvar j = 0; j + 1 < NM; j++) begin : g_mfill
    // R5
    m_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid[j+1] |-> issue_valid[j]);
  end

  for (genvar j = 0; j + 1 < NI; j++) begin : g_ifill
    // R5
    i_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid[BI+j+1] |-> issue_valid[BI+j]);
  end

  for (genvar j = 0; j + 1 < NB; j++) begin : g_bfill
    // R5
    b_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid[BB+j+1] |-> issue_valid[BB+j]);
  end
endmodule

bind vdisp_top vdisp_chk #(.NM(NM), .NI(NI), .NF(NF), .NB(NB)) u_chk (.*);

// File: tb/tb_vdisp_top.sv
module tb_vdisp_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   in_valid = 2'b00;
  logic [1:0]   in_ready;
  logic [255:0] in_bundle = '0;
  logic [8:0]   issue_valid;
  logic [368:0] issue_op;
  logic [368:0] issue_ext;
  logic [8:0]   issue_long;
  logic         tmpl_err;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vdisp_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bundle(in_bundle), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_ext(issue_ext), .issue_long(issue_long), .tmpl_err(tmpl_err)
  );

  // {tmpl A, tmpl B, expected ports cycle 1, cycle 2, cycle 3}
  localparam logic [36:0] VEC [0:10] = '{
    {5'd0,  5'd0,  9'h00F, 9'h00C, 9'h000},
    {5'd1,  5'd0,  9'h00D, 9'h00D, 9'h000},
    {5'd2,  5'd12, 9'h005, 9'h01D, 9'h000},
    {5'd4,  5'd4,  9'h00F, 9'h000, 9'h000},
    {5'd0,  5'd4,  9'h04F, 9'h000, 9'h000},
    {5'd14, 5'd8,  9'h013, 9'h007, 9'h000},
    {5'd22, 5'd18, 9'h1C1, 9'h0C0, 9'h000},
    {5'd10, 5'd29, 9'h001, 9'h057, 9'h000},
    {5'd17, 5'd24, 9'h045, 9'h043, 9'h000},
    {5'd13, 5'd15, 9'h015, 9'h013, 9'h000},
    {5'd6,  5'd0,  9'h00D, 9'h000, 9'h000}
  };

  function automatic string vreq(input int i);
    case (i)
      0: return "R5";
      1, 2, 7: return "R3";
      3, 4: return "R6";
      5, 6: return "R4";
      10: return "R7";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [127:0] mk(input logic [4:0] t, input logic [40:0] base);
    return {base + 41'd2, base + 41'd1, base, t};
  endfunction

  function automatic logic [40:0] opat(input int p);
    return issue_op[p*41 +: 41];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, leave at the next falling edge with inputs idle
  task automatic load(input logic [1:0] v, input logic [127:0] b0, input logic [127:0] b1);
    in_valid  = v;
    in_bundle = {b1, b0};
    @(negedge clk);
    in_valid = 2'b00;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "issue_valid in reset", 64'(issue_valid), 64'h0);
    chk("R10", "in_ready in reset", 64'(in_ready), 64'h3);
    chk("R10", "tmpl_err in reset", 64'(tmpl_err), 64'h0);
    rst_n = 1'b1;
    tick();
    chk("R10", "issue_valid after reset", 64'(issue_valid), 64'h0);

    for (int i = 0; i < 11; i++) begin
      load(2'b11, mk(VEC[i][36:32], 41'h100 * (i + 1)), mk(VEC[i][31:27], 41'h100 * (i + 1) + 41'h80));
      chk(vreq(i), $sformatf("vec %0d cycle 1", i), 64'(issue_valid), 64'(VEC[i][26:18]));
      tick();
      chk(vreq(i), $sformatf("vec %0d cycle 2", i), 64'(issue_valid), 64'(VEC[i][17:9]));
      tick();
      chk(vreq(i), $sformatf("vec %0d cycle 3", i), 64'(issue_valid), 64'(VEC[i][8:0]));
    end

    // payload placement and long operation on a B port
    load(2'b11, mk(5'd0, 41'h10), mk(5'd4, 41'h20));
    chk("R1", "M0 payload", 64'(opat(0)), 64'h10);
    chk("R1", "I0 payload", 64'(opat(2)), 64'h11);
    chk("R1", "I1 payload", 64'(opat(3)), 64'h12);
    chk("R1", "M1 payload", 64'(opat(1)), 64'h20);
    chk("R6", "B0 long op", 64'(opat(6)), 64'h21);
    chk("R6", "B0 long ext", 64'(issue_ext[6*41 +: 41]), 64'h22);
    chk("R6", "long flags", 64'(issue_long), 64'h040);
    tick();
    chk("R6", "drained", 64'(issue_valid), 64'h0);

    // reserved template alone on lane 0
    load(2'b01, mk(5'd20, 41'h30), '0);
    chk("R7", "err pulse", 64'(tmpl_err), 64'h1);
    chk("R7", "no issue", 64'(issue_valid), 64'h0);
    tick();
    chk("R7", "err cleared", 64'(tmpl_err), 64'h0);

    // older entry still busy: no lane free
    load(2'b11, mk(5'd2, 41'h40), mk(5'd12, 41'h50));
    chk("R8", "ready when full", 64'(in_ready), 64'h0);
    tick();
    tick();

    // single rotation, lane 1 refused
    load(2'b11, mk(5'd14, 41'h60), mk(5'd8, 41'h70));
    chk("R8", "ready one free", 64'(in_ready), 64'h1);
    in_valid  = 2'b11;
    in_bundle = {mk(5'd0, 41'h90), mk(5'd0, 41'h80)};
    @(negedge clk);
    in_valid = 2'b00;
    chk("R9", "single rotation cycle 2", 64'(issue_valid), 64'h007);
    chk("R8", "ready one free again", 64'(in_ready), 64'h1);
    tick();
    chk("R9", "new bundle issues", 64'(issue_valid), 64'h00D);
    chk("R9", "new bundle I0 payload", 64'(opat(2)), 64'h81);
    tick();
    chk("R8", "lane 1 not taken", 64'(issue_valid), 64'h0);

    // double rotation
    load(2'b11, mk(5'd4, 41'hA0), mk(5'd4, 41'hB0));
    chk("R9", "ready both free", 64'(in_ready), 64'h3);
    in_valid  = 2'b11;
    in_bundle = {mk(5'd0, 41'hD0), mk(5'd1, 41'hC0)};
    @(negedge clk);
    in_valid = 2'b00;
    chk("R9", "double rotation first", 64'(issue_valid), 64'h00D);
    chk("R9", "first new M0 payload", 64'(opat(0)), 64'hC0);
    tick();
    chk("R9", "double rotation second", 64'(issue_valid), 64'h00D);
    chk("R9", "second new M0 payload", 64'(opat(0)), 64'hD0);
    tick();
    chk("R9", "window empty", 64'(issue_valid), 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog R10 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule